// File: doc/BRIEF.md
# Run-Time Programmable Clock Divider with Bypass

This block derives a slower clock from an input clock, with the division ratio given at run time by an 8-bit code. Ratios from 2 to 256 come from a counter that advances only on the rising edge of the input clock. The counter drives a registered output level. A ratio of 1 does not use the counter. Instead, a select register steers the raw input clock to the output, so the output runs at the full input rate.

A period always starts with the output rising together with an input rising edge. The high phase is the shorter half of the period, so even ratios give a 50% duty cycle. Odd ratios miss 50% by half an input period. A new code takes effect only at the boundary between two periods, so a period in progress is never cut short or stretched. The output select changes only at that boundary. At that point the output level is low and the input clock is just rising, so the switch into or out of bypass does not chop a pulse.

Top module: `prog_clk_div`

## Requirements
- R1: The 8-bit code `div_sel` selects ratio N: a code value of 1 to 255 gives N equal to the code, and code 0 gives N = 256. Outside bypass, the output period is exactly N input cycles.
- R2: With N = 1, `clk_out` follows `clk_in` in both the high and the low half of every input cycle.
- R3: For an even N of at least 2, the output is high for N/2 input cycles and low for N/2 input cycles. The output rises on the input rising edge that starts a period.
- R4: For an odd N of at least 3, the output is high for (N-1)/2 input cycles and low for (N+1)/2 input cycles.
- R5: The code is sampled only on the rising edge that ends the last cycle of a period. A change of `div_sel` inside a period leaves that period's high and low times unchanged, and the new ratio applies from the next period.
- R6: While `rst_n` is low, `clk_out` is low and the period counter is cleared. After `rst_n` rises, the first period starts on the third rising edge of `clk_in`. For N of at least 2, the output goes high on that edge. For N = 1, the output follows the input from that edge on.
- R7: The internal period position always stays below the current ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_sel | input | 8 | Division code; 0 means 256, 1 means bypass |
| clk_out | output | 1 | Divided or bypassed clock |

## Verification
The bound checker watches four things on every cycle. The position counter must stay within the ratio. The latched ratio may change only at a period boundary. Every period must open high and close low. The bypass select may be set only when the ratio is 1. The exact high and low run lengths for ratios 1, 2, 3, 7, 8 and 256 come from the bench's scenarios. So do the three-edge start after reset release, and the rule that a code change in mid-period waits for the next period. A behavioural reference model in the bench predicts the output level in each half of every input cycle, and the bench compares against it throughout.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // Default width of the division code; the ratio range is 1 .. 2**SEL_W.
  localparam int unsigned DEF_SEL_W = 8;
  // Depth of the reset release synchronizer.
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release of the active-low reset.
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = clkdiv_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_ratio_ctl.sv
`timescale 1ns/1ps
// Period position counter and ratio latch; the code is loaded only at wrap.
module clkdiv_ratio_ctl #(
  parameter int unsigned SEL_W = clkdiv_pkg::DEF_SEL_W,
  localparam int unsigned RW   = SEL_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic [RW-1:0] cnt_q,
  output logic [RW-1:0] ratio_q,
  output logic [RW-1:0] cnt_d,
  output logic [RW-1:0] ratio_d
);
  logic          wrap;
  logic          load_en;
  logic [RW-1:0] sel_ratio;

  // Code zero stands for the largest ratio, 2**SEL_W.
  always_comb begin
    if (sel == '0) begin
      sel_ratio = RW'(1) << SEL_W;
    end else begin
      sel_ratio = {1'b0, sel};
    end
  end

  always_comb begin
    wrap    = (cnt_q == (ratio_q - RW'(1)));
    load_en = wrap;
    if (load_en) begin
      cnt_d   = '0;
      ratio_d = sel_ratio;
    end else begin
      cnt_d   = cnt_q + RW'(1);
      ratio_d = ratio_q;
    end
  end

  // Reset ratio of 1 makes the first active edge a wrap, which loads the code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RW'(1);
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end
endmodule

// File: rtl/clkdiv_wave.sv
`timescale 1ns/1ps
// Registered output level and bypass select, computed from next-state position.
module clkdiv_wave #(
  parameter int unsigned SEL_W = clkdiv_pkg::DEF_SEL_W,
  localparam int unsigned RW   = SEL_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] cnt_d,
  input  logic [RW-1:0] ratio_d,
  output logic          level_q,
  output logic          byp_q
);
  logic          level_d;
  logic          byp_d;
  logic [RW-1:0] high_len;

  always_comb begin
    high_len = ratio_d >> 1;
    byp_d    = (ratio_d == RW'(1));
    level_d  = !byp_d && (cnt_d < high_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      byp_q   <= byp_d;
    end
  end
endmodule

// File: rtl/clkdiv_outmux.sv
`timescale 1ns/1ps
// Output select between the raw input clock and the divided level.
module clkdiv_outmux (
  input  logic clk_raw,
  input  logic level,
  input  logic byp,
  output logic clk_sel
);
  always_comb begin
    if (byp) begin
      clk_sel = clk_raw;
    end else begin
      clk_sel = level;
    end
  end
endmodule

// File: rtl/prog_clk_div.sv
`timescale 1ns/1ps
module prog_clk_div #(
  parameter int unsigned SEL_W  = clkdiv_pkg::DEF_SEL_W,
  parameter int unsigned STAGES = clkdiv_pkg::DEF_SYNC_STAGES
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             clk_out
);
  localparam int unsigned RW = SEL_W + 1;

  logic          rst_n_s;
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] cnt_d;
  logic [RW-1:0] ratio_d;
  logic          div_q;
  logic          byp_q;

  clkdiv_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  clkdiv_ratio_ctl #(.SEL_W(SEL_W)) u_ctl (
    .clk     (clk_in),
    .rst_n   (rst_n_s),
    .sel     (div_sel),
    .cnt_q   (cnt_q),
    .ratio_q (ratio_q),
    .cnt_d   (cnt_d),
    .ratio_d (ratio_d)
  );

  clkdiv_wave #(.SEL_W(SEL_W)) u_wave (
    .clk     (clk_in),
    .rst_n   (rst_n_s),
    .cnt_d   (cnt_d),
    .ratio_d (ratio_d),
    .level_q (div_q),
    .byp_q   (byp_q)
  );

  clkdiv_outmux u_mux (
    .clk_raw (clk_in),
    .level   (div_q),
    .byp     (byp_q),
    .clk_sel (clk_out)
  );
endmodule

// File: rtl/clkdiv_chk.sv
`timescale 1ns/1ps
module clkdiv_chk #(
  parameter int unsigned SEL_W = clkdiv_pkg::DEF_SEL_W,
  localparam int unsigned RW   = SEL_W + 1
) (
  input logic          clk_in,
  input logic          rst_n_s,
  input logic [RW-1:0] cnt_q,
  input logic [RW-1:0] ratio_q,
  input logic          div_q,
  input logic          byp_q
);
  p_cnt_range_r7: assert property (@(posedge clk_in) disable iff (!rst_n_s)
    cnt_q < ratio_q);

  p_ratio_hold_r5: assert property (@(posedge clk_in) disable iff (!rst_n_s)
    (cnt_q != (ratio_q - RW'(1))) |=> $stable(ratio_q));

  p_start_high_r3: assert property (@(posedge clk_in) disable iff (!rst_n_s)
    (ratio_q > RW'(1) && cnt_q == '0) |-> div_q);

  p_end_low_r4: assert property (@(posedge clk_in) disable iff (!rst_n_s)
    (ratio_q > RW'(1) && cnt_q == (ratio_q - RW'(1))) |-> !div_q);

  p_bypass_only_r2: assert property (@(posedge clk_in) disable iff (!rst_n_s)
    byp_q |-> (ratio_q == RW'(1)));
endmodule

bind prog_clk_div clkdiv_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_in  (clk_in),
  .rst_n_s (rst_n_s),
  .cnt_q   (cnt_q),
  .ratio_q (ratio_q),
  .div_q   (div_q),
  .byp_q   (byp_q)
);

// File: tb/tb_prog_clk_div.sv
`timescale 1ns/1ps
module tb_prog_clk_div;
  logic       clk_in;
  logic       rst_n;
  logic [7:0] div_sel;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  prog_clk_div dut (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .clk_out (clk_out)
  );

  initial clk_in = 1'b0;
  always #2.5 clk_in = ~clk_in;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Behavioural reference model, checked in both halves of every input cycle.
  int m_edges = 0;
  bit m_run   = 0;
  int m_n     = 1;
  int m_ph    = 0;
  initial begin
    forever begin
      @(posedge clk_in);
      if (!rst_n) begin
        m_edges = 0;
        m_run   = 0;
      end else begin
        m_edges++;
        if (m_edges >= 3) begin
          if (!m_run || m_ph == m_n - 1) begin
            m_n   = (div_sel == 0) ? 256 : int'(div_sel);
            m_ph  = 0;
            m_run = 1;
          end else begin
            m_ph++;
          end
        end
      end
      #1;
      begin
        int e_hi;
        e_hi = (!rst_n || !m_run) ? 0 : (m_n == 1) ? 1 : int'(m_ph < m_n / 2);
        check(clk_out == e_hi, "R1/R6 model high half", int'(clk_out), e_hi);
      end
      @(negedge clk_in);
      #1;
      begin
        int e_lo;
        e_lo = (!rst_n || !m_run || m_n == 1) ? 0 : int'(m_ph < m_n / 2);
        check(clk_out == e_lo, "R2/R5 model low half", int'(clk_out), e_lo);
      end
    end
  end

  // Sample the output in the high half of the next input cycle.
  task automatic sample(output bit s);
    @(posedge clk_in);
    #1;
    s = clk_out;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev;
    bit s;
    ok = 0;
    sample(prev);
    for (int i = 0; i < 1200; i++) begin
      sample(s);
      if (!prev && s) begin
        ok = 1;
        break;
      end
      prev = s;
    end
  endtask

  // Counts high then low run lengths, starting just after a detected rise.
  task automatic runs(output int h, output int l);
    bit s;
    h = 1;
    l = 0;
    sample(s);
    while (s && h < 600) begin
      h++;
      sample(s);
    end
    while (!s && l < 600) begin
      l++;
      sample(s);
    end
  endtask

  task automatic measure(input logic [7:0] code, input int eh, input int el, input string tag);
    bit ok;
    int h;
    int l;
    @(negedge clk_in);
    div_sel = code;
    wait_rise(ok);
    wait_rise(ok);
    check(ok, {tag, " rise seen"}, int'(ok), 1);
    runs(h, l);
    check(h == eh, {tag, " high time"}, h, eh);
    check(l == el, {tag, " low time"}, l, el);
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    bit ok;
    int h;
    int l;
    rst_n   = 1'b0;
    div_sel = 8'd4;
    repeat (4) @(posedge clk_in);
    #1;
    check(clk_out == 1'b0, "R6 output low in reset", int'(clk_out), 0);

    // R6: first period starts on the third rising edge after release.
    @(negedge clk_in);
    rst_n = 1'b1;
    @(posedge clk_in); #1;
    check(clk_out == 1'b0, "R6 edge 1 after release", int'(clk_out), 0);
    @(posedge clk_in); #1;
    check(clk_out == 1'b0, "R6 edge 2 after release", int'(clk_out), 0);
    @(posedge clk_in); #1;
    check(clk_out == 1'b1, "R6 edge 3 after release", int'(clk_out), 1);

    measure(8'd2, 1, 1, "R3 ratio 2");
    measure(8'd8, 4, 4, "R3 ratio 8");
    measure(8'd3, 1, 2, "R4 ratio 3");
    measure(8'd7, 3, 4, "R4 ratio 7");
    measure(8'd0, 128, 128, "R1 code 0 ratio 256");

    // R2: bypass follows the input clock in both halves.
    @(negedge clk_in);
    div_sel = 8'd1;
    repeat (300) @(posedge clk_in);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_in); #1;
      check(clk_out == 1'b1, "R2 bypass high half", int'(clk_out), 1);
      @(negedge clk_in); #1;
      check(clk_out == 1'b0, "R2 bypass low half", int'(clk_out), 0);
    end

    // R5: a code change inside a period waits for the next period.
    measure(8'd6, 3, 3, "R5 ratio 6 steady");
    wait_rise(ok);
    @(negedge clk_in);
    div_sel = 8'd2;
    runs(h, l);
    check(h == 3, "R5 old period high kept", h, 3);
    check(l == 3, "R5 old period low kept", l, 3);
    runs(h, l);
    check(h == 1 && l == 1, "R5 new ratio next period", h * 10 + l, 11);

    // R6: reset in the middle of operation.
    @(negedge clk_in);
    div_sel = 8'd5;
    rst_n   = 1'b0;
    #1;
    check(clk_out == 1'b0, "R6 mid-run reset low", int'(clk_out), 0);
    repeat (3) @(posedge clk_in);
    @(negedge clk_in);
    rst_n = 1'b1;
    measure(8'd5, 2, 3, "R4 ratio 5 after reset");

    repeat (4) @(posedge clk_in);
    finish_up();
  end
endmodule